// File: doc/BRIEF.md
# Supply and Fault Restart Sequencer

This block sequences a self-powered switching controller. It decides when the high-voltage charging source may feed the supply capacitor and when the power switch may be driven. It also qualifies overcurrent trips from the current-sense comparator. Every analog decision arrives as a digital comparator flag: drain above the start level, supply above the turn-on level, supply below the restart level, supply below the turn-off level, and current sense above the fault level. All of these flags are resynchronised inside the block. Two further inputs are already synchronous to the block clock: a one-cycle strobe that marks the end of each switching cycle, and a flag that is high while the gate is off.

After power-up the charger fills the supply until the turn-on flag rises. Switching then starts and the charger stops. While the block is running, a supply that sags below the restart level is topped up, but only while the gate is off. One overcurrent cycle on its own is forgiven. A second trip in the very next cycle latches a fault: switching stops and the charger is held off, so the supply decays. When the supply reaches undervoltage, the latch clears and a saturating hiccup counter steps. The block then charges again, and the whole start-up repeats.

Top module: `hv_supply_seq`

## Requirements
- R1: `charge_en` is 0 whenever the synchronised drain-ok flag is 0, in every state.
- R2: From the off state, the charger is on (`charge_en`=1, `sw_en`=0) until the turn-on flag is seen. The block then runs with `sw_en`=1 and `charge_en`=0.
- R3: While running with the restart flag set, `charge_en` equals `gate_off` (gated by drain-ok). This lasts until the turn-on flag returns, after which the charger stays off.
- R4: The undervoltage flag forces `sw_en` to 0 and returns the block to the off state with the charger on.
- R5: A trip in one switching cycle, followed by a cycle with no trip, leaves `sw_en`=1 and `fault_active`=0. A cycle's trip is the current-sense flag seen at any clock of that cycle up to and including its end strobe.
- R6: Trips in two consecutive switching cycles set `fault_active`=1 and `sw_en`=0.
- R7: While the fault is latched, `charge_en` stays 0 even when the supply is below the restart level and the gate is off.
- R8: The undervoltage flag clears a latched fault, steps `restart_cnt` by 1 and restarts charging.
- R9: `restart_cnt` saturates at 2^CNT_W-1.
- R10: After reset, the block is in the off state: `sw_en`=0, `fault_active`=0, `restart_cnt`=0, and the charger is enabled as soon as drain-ok is seen.
- R11: Each comparator flag passes through a two-flop synchroniser. A change takes effect at the outputs after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_ok_a | input | 1 | Drain above start level (asynchronous) |
| vcc_on_a | input | 1 | Supply above turn-on level (asynchronous) |
| vcc_low_a | input | 1 | Supply below restart level (asynchronous) |
| vcc_uv_a | input | 1 | Supply below turn-off level (asynchronous) |
| cs_trip_a | input | 1 | Current sense above fault level (asynchronous) |
| cycle_end | input | 1 | One-cycle strobe at the end of each switching cycle |
| gate_off | input | 1 | High during the switch off-time |
| charge_en | output | 1 | Charging source enable |
| sw_en | output | 1 | Switching enable |
| fault_active | output | 1 | Overcurrent fault latched |
| restart_cnt | output | CNT_W | Saturating count of hiccup restarts |

## Verification
The supply path is driven through a walk of comparator patterns: start-up, running, a sagging supply with the gate both on and off, loss of drain voltage, and undervoltage. Together these separate the off-time-only recharge from unconditional charging, and separate drain gating from the state decode. The overcurrent path receives an isolated trip, a trip–clean–trip sequence and two back-to-back trips. These distinguish a qualifier that forgives a lone trip from one that latches at once or that counts trips that are not consecutive. Repeated hiccups push the restart counter past its maximum. A one-edge probe shows that the synchroniser depth is exactly two.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_RUN   = 2'd1,
        PS_RECHG = 2'd2,
        PS_LATCH = 2'd3
    } pwr_state_e;

    typedef enum logic {
        OQ_IDLE = 1'b0,
        OQ_WARN = 1'b1
    } ocp_state_e;

    typedef struct packed {
        logic drain_ok;
        logic vcc_on;
        logic vcc_low;
        logic vcc_uv;
        logic cs_trip;
    } cmp_flags_t;

    localparam int NUM_CMP = $bits(cmp_flags_t);

    function automatic logic is_switching(pwr_state_e s);
        return (s == PS_RUN) || (s == PS_RECHG);
    endfunction

endpackage

// File: rtl/sseq_sync.sv
module sseq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sseq_ocp_qual.sv
module sseq_ocp_qual
    import sseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_active,
    input  logic cycle_end,
    input  logic trip,
    output logic confirm
);
    ocp_state_e state_q;
    logic       trip_seen_q;
    logic       hit;

    assign hit     = trip_seen_q | trip;
    assign confirm = sw_active & cycle_end & hit & (state_q == OQ_WARN);

    always_ff @(posedge clk) begin
        if (rst || !sw_active) begin
            state_q     <= OQ_IDLE;
            trip_seen_q <= 1'b0;
        end else if (cycle_end) begin
            trip_seen_q <= 1'b0;
            state_q     <= (hit && state_q == OQ_IDLE) ? OQ_WARN : OQ_IDLE;
        end else if (trip) begin
            trip_seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sseq_pwr_fsm.sv
module sseq_pwr_fsm
    import sseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drain_ok,
    input  logic vcc_on,
    input  logic vcc_low,
    input  logic vcc_uv,
    input  logic gate_off,
    input  logic confirm,
    output logic charge_en,
    output logic sw_en,
    output logic fault_active,
    output logic hiccup
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        hiccup  = 1'b0;
        unique case (state_q)
            PS_OFF: if (vcc_on && !vcc_uv) state_d = PS_RUN;
            PS_RUN: begin
                if (vcc_uv)       state_d = PS_OFF;
                else if (confirm) state_d = PS_LATCH;
                else if (vcc_low) state_d = PS_RECHG;
            end
            PS_RECHG: begin
                if (vcc_uv)       state_d = PS_OFF;
                else if (confirm) state_d = PS_LATCH;
                else if (vcc_on)  state_d = PS_RUN;
            end
            PS_LATCH: begin
                if (vcc_uv) begin
                    state_d = PS_OFF;
                    hiccup  = 1'b1;
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        charge_en = 1'b0;
        unique case (state_q)
            PS_OFF:   charge_en = drain_ok & ~vcc_on;
            PS_RECHG: charge_en = drain_ok & gate_off & ~vcc_on;
            default:  charge_en = 1'b0;
        endcase
    end

    assign sw_en        = is_switching(state_q) & ~vcc_uv;
    assign fault_active = (state_q == PS_LATCH);
endmodule

// File: rtl/sseq_sat_counter.sv
module sseq_sat_counter #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end
endmodule

// File: rtl/hv_supply_seq.sv
module hv_supply_seq
    import sseq_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drain_ok_a,
    input  logic             vcc_on_a,
    input  logic             vcc_low_a,
    input  logic             vcc_uv_a,
    input  logic             cs_trip_a,
    input  logic             cycle_end,
    input  logic             gate_off,
    output logic             charge_en,
    output logic             sw_en,
    output logic             fault_active,
    output logic [CNT_W-1:0] restart_cnt
);
    cmp_flags_t raw_flags, flags_s;
    logic [NUM_CMP-1:0] sync_q;
    logic drain_s, uv_s, confirm, hiccup;

    assign raw_flags = '{drain_ok: drain_ok_a, vcc_on: vcc_on_a,
                         vcc_low: vcc_low_a, vcc_uv: vcc_uv_a,
                         cs_trip: cs_trip_a};

    sseq_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(raw_flags), .q(sync_q)
    );

    assign flags_s = cmp_flags_t'(sync_q);
    assign drain_s = flags_s.drain_ok;
    assign uv_s    = flags_s.vcc_uv;

    sseq_ocp_qual ocp_i (
        .clk(clk), .rst(rst), .sw_active(sw_en), .cycle_end(cycle_end),
        .trip(flags_s.cs_trip), .confirm(confirm)
    );

    sseq_pwr_fsm fsm_i (
        .clk(clk), .rst(rst), .drain_ok(drain_s), .vcc_on(flags_s.vcc_on),
        .vcc_low(flags_s.vcc_low), .vcc_uv(uv_s), .gate_off(gate_off),
        .confirm(confirm), .charge_en(charge_en), .sw_en(sw_en),
        .fault_active(fault_active), .hiccup(hiccup)
    );

    sseq_sat_counter #(.WIDTH(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .inc(hiccup), .count(restart_cnt)
    );
endmodule

// File: rtl/hv_supply_seq_chk.sv
module hv_supply_seq_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             drain_s,
    input logic             uv_s,
    input logic             charge_en,
    input logic             sw_en,
    input logic             fault_active,
    input logic [CNT_W-1:0] restart_cnt
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    a_r1_no_charge_without_drain: assert property (@(posedge clk) disable iff (rst)
        !drain_s |-> !charge_en);
    a_r4_uv_blocks_switching: assert property (@(posedge clk) disable iff (rst)
        uv_s |-> !sw_en);
    a_r6_fault_stops_switching: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> !sw_en);
    a_r6_fault_from_running: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_active) |-> $past(sw_en));
    a_r7_latch_holds_charger_off: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> !charge_en);
    a_r8_clear_on_uv: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_active) |-> $past(uv_s));
    a_r8_count_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (restart_cnt != $past(restart_cnt)) |-> (restart_cnt == $past(restart_cnt) + 1'b1));
    a_r9_count_saturates: assert property (@(posedge clk) disable iff (rst)
        ($past(restart_cnt) == MAXV) |-> (restart_cnt == MAXV));
endmodule

bind hv_supply_seq hv_supply_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .drain_s(drain_s), .uv_s(uv_s),
    .charge_en(charge_en), .sw_en(sw_en), .fault_active(fault_active),
    .restart_cnt(restart_cnt)
);

// File: tb/hv_supply_seq_tb_top.sv
`timescale 1ns/1ps
module hv_supply_seq_tb_top;
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drain_ok_a = 0, vcc_on_a = 0, vcc_low_a = 1, vcc_uv_a = 1, cs_trip_a = 0;
    logic cycle_end = 0, gate_off = 0;
    logic charge_en, sw_en, fault_active;
    logic [CNT_W-1:0] restart_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hv_supply_seq #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .drain_ok_a(drain_ok_a), .vcc_on_a(vcc_on_a),
        .vcc_low_a(vcc_low_a), .vcc_uv_a(vcc_uv_a), .cs_trip_a(cs_trip_a),
        .cycle_end(cycle_end), .gate_off(gate_off), .charge_en(charge_en),
        .sw_en(sw_en), .fault_active(fault_active), .restart_cnt(restart_cnt)
    );

    // Row fields: [6]drain [5]turn-on [4]restart [3]undervoltage [2]gate_off
    //             [1]expected charge_en [0]expected sw_en
    localparam int NROW = 11;
    localparam logic [6:0] VEC [NROW] = '{
        7'b0011000, // R1 no drain, no charge
        7'b1011010, // R2 charging from off
        7'b1010010, // R2
        7'b1000010, // R2
        7'b1100001, // R2 turn-on reached
        7'b1000001, // R2 running, charger off
        7'b1010001, // R3 sag, gate on
        7'b1010111, // R3 sag, gate off
        7'b0010101, // R1 sag, gate off, no drain
        7'b1100101, // R3 turn-on again
        7'b1011010  // R4 undervoltage
    };

    function automatic string row_tag(int r);
        case (r)
            0, 8:    return "R1";
            6, 7, 9: return "R3";
            10:      return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_cycle(input logic trip);
        cs_trip_a = trip;
        ticks(4);
        cs_trip_a = 0;
        ticks(4);
        cycle_end = 1;
        ticks(1);
        cycle_end = 0;
        ticks(1);
    endtask

    task automatic set_sup(input logic d, input logic on, input logic low, input logic uv);
        drain_ok_a = d; vcc_on_a = on; vcc_low_a = low; vcc_uv_a = uv;
    endtask

    task automatic hiccup_once();
        set_sup(1, 1, 0, 0); ticks(5);
        set_sup(1, 0, 0, 0); ticks(2);
        end_cycle(1);
        end_cycle(1);
        set_sup(1, 0, 1, 1); ticks(5);
    endtask

    initial begin
        ticks(3);
        rst = 0;
        ticks(1);
        // R10 reset state
        check("R10", "sw_en after reset", sw_en, 0);
        check("R10", "fault after reset", fault_active, 0);
        check("R10", "count after reset", restart_cnt, 0);

        // R11 synchroniser depth
        drain_ok_a = 1;
        ticks(1);
        check("R11", "charge_en after one edge", charge_en, 0);
        ticks(1);
        check("R11", "charge_en after two edges", charge_en, 1);
        check("R10", "charger enabled in off state", charge_en, 1);

        // Table walk of the supply sequencing
        for (int r = 0; r < NROW; r++) begin
            set_sup(VEC[r][6], VEC[r][5], VEC[r][4], VEC[r][3]);
            gate_off = VEC[r][2];
            ticks(5);
            check(row_tag(r), $sformatf("row %0d charge_en", r), charge_en, VEC[r][1]);
            check(row_tag(r), $sformatf("row %0d sw_en", r), sw_en, VEC[r][0]);
        end
        gate_off = 0;

        // R5 isolated trip forgiven
        set_sup(1, 1, 0, 0); ticks(5);
        set_sup(1, 0, 0, 0); ticks(2);
        check("R2", "running before trips", sw_en, 1);
        end_cycle(1);
        end_cycle(0);
        check("R5", "lone trip sw_en", sw_en, 1);
        check("R5", "lone trip fault", fault_active, 0);
        // R5 trip, clean, trip is not consecutive
        end_cycle(1);
        end_cycle(0);
        end_cycle(1);
        check("R5", "non-consecutive fault", fault_active, 0);
        end_cycle(0);

        // R6 two consecutive trips
        end_cycle(1);
        check("R6", "fault after first trip", fault_active, 0);
        end_cycle(1);
        check("R6", "fault latched", fault_active, 1);
        check("R6", "switching stopped", sw_en, 0);

        // R7 charger held off during latch
        set_sup(1, 0, 1, 0); gate_off = 1; ticks(6);
        check("R7", "charge_en in latch", charge_en, 0);
        check("R7", "fault still latched", fault_active, 1);
        gate_off = 0;

        // R8 clear on undervoltage
        set_sup(1, 0, 1, 1); ticks(5);
        check("R8", "fault cleared", fault_active, 0);
        check("R8", "count stepped", restart_cnt, 1);
        check("R8", "charging resumed", charge_en, 1);

        // R9 saturation
        for (int k = 0; k < 8; k++) hiccup_once();
        check("R9", "count saturated", restart_cnt, CMAX);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule